// File: doc/BRIEF.md
# Block Move and Search Engine

This block carries out one iteration of the block-copy and block-search operations of an 8-bit processor. It works from three 16-bit registers: a source pointer, a destination pointer and a byte counter. It also uses the accumulator and the current flag byte. A caller selects the operation with three mode bits: compare or move, decrement or increment, repeating or single. The caller then pulses `start`. The block runs its memory accesses over a simple request/acknowledge byte interface. It then returns the stepped pointers, the decremented counter and the new flag byte, with a one-cycle `done` pulse.

A move reads the byte at the source pointer and writes it to the destination pointer. A compare reads the byte at the source pointer and subtracts it from the accumulator. It keeps only the flags and never writes memory. For a repeating operation the block also raises `rewind` with `done` when the instruction must execute again, meaning the program counter steps back by two. The caller then starts the next iteration with the returned register values. Instruction decode and interrupt sampling between iterations belong to the caller.

Flag byte layout (bit 7 down to bit 0): S, Z, Y, H, X, P/V, N, C.

Top module: `blk_xfer_engine`

## Requirements
- R1: For a move (`op_cmp`=0), exactly one read at address `hl_in` is made first, then exactly one write of that byte to address `de_in`. A request holds its address and direction until it is acknowledged.
- R2: The source pointer steps by +1 (`op_dec`=0) or -1 (`op_dec`=1) modulo 65536. For a move the destination pointer steps the same way. For a compare `de_out` equals `de_in`.
- R3: The counter leaves as `bc_in` minus one modulo 65536, so a starting count of 0 leaves as 0xFFFF.
- R4: After a move, H (bit 4) and N (bit 1) are 0 and P/V (bit 2) is 1 exactly when `bc_out` is nonzero. Y (bit 5) is bit 1 and X (bit 3) is bit 3 of the 8-bit sum of the moved byte and the accumulator. S, Z and C keep their `flags_in` values.
- R5: After a compare of difference D = accumulator minus byte, S is D bit 7 and Z is set when D is zero. H is set when the accumulator's low nibble is below the byte's low nibble. N is 1, P/V is 1 exactly when `bc_out` is nonzero, and C keeps its `flags_in` value.
- R6: After a compare, Y is bit 1 and X is bit 3 of D minus the new H bit.
- R7: A repeating move raises `rewind` with `done` when `bc_out` is nonzero. A single operation never raises `rewind`.
- R8: A repeating compare raises `rewind` only when D is nonzero and `bc_out` is nonzero, so a search stops on a match or on an exhausted count.
- R9: A compare makes one read and no write.
- R10: `done` is a one-cycle pulse per iteration, and `busy` is low while `done` is high. A `start` that arrives while `busy` is high has no effect on the running iteration or on the results.
- R11: After reset there is no memory request, `busy`, `done` and `rewind` are low, and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one iteration (taken only while idle) |
| op_cmp | input | 1 | 1 = compare, 0 = move |
| op_dec | input | 1 | 1 = pointers step down, 0 = step up |
| op_rpt | input | 1 | 1 = repeating form |
| hl_in | input | 16 | Source pointer |
| de_in | input | 16 | Destination pointer |
| bc_in | input | 16 | Byte counter |
| acc_in | input | 8 | Accumulator |
| flags_in | input | 8 | Flag byte before the iteration |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access complete in this cycle |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| rewind | output | 1 | Repeat needed (program counter back by two) |
| hl_out | output | 16 | Stepped source pointer |
| de_out | output | 16 | Destination pointer after the iteration |
| bc_out | output | 16 | Decremented counter |
| flags_out | output | 8 | New flag byte |

## Verification
Moves are tried with ascending and descending pointers, and with pointers sitting at 0xFFFF and 0x0000 so that both wrap directions and the zero-count case are reached. Single compares use a matching byte and a byte whose low nibble exceeds the accumulator's. These separate the Z, H and adjusted X/Y results. Repeating searches are run to a match part-way through a buffer and to exhaustion without a match, so that the two stop rules are told apart by iteration count and final flags. A repeating descending copy checks the copied memory, and a `start` pulse injected during a slow access checks that a busy engine ignores it.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic cmp;
        logic dec;
        logic rpt;
    } op_mode_t;

    localparam int FB_S = 7;
    localparam int FB_Z = 6;
    localparam int FB_Y = 5;
    localparam int FB_H = 4;
    localparam int FB_X = 3;
    localparam int FB_P = 2;
    localparam int FB_N = 1;
    localparam int FB_C = 0;

    localparam int SRC_Y_BIT = 1;
    localparam int SRC_X_BIT = 3;

endpackage

// File: rtl/blk_xfer_step.sv
module blk_xfer_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         en,
    input  logic         down,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        if (!en)
            nxt = val;
        else if (down)
            nxt = val - ONE;
        else
            nxt = val + ONE;
    end
endmodule

// File: rtl/blk_xfer_flags.sv
module blk_xfer_flags
    import blk_xfer_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          is_cmp,
    input  logic          rpt,
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] acc,
    input  logic [7:0]    flags_old,
    input  logic [CW-1:0] cnt_next,
    output logic [7:0]    flags_new,
    output logic          again
);
    logic [DW-1:0] sum_v;
    logic [DW-1:0] diff_v;
    logic [DW-1:0] adj_v;
    logic          hbor;
    logic          cnt_nz;

    always_comb begin
        sum_v  = data + acc;
        diff_v = acc - data;
        hbor   = (acc[3:0] < data[3:0]);
        adj_v  = diff_v - {{(DW-1){1'b0}}, hbor};
        cnt_nz = |cnt_next;

        flags_new = flags_old;
        flags_new[FB_P] = cnt_nz;
        if (is_cmp) begin
            flags_new[FB_S] = diff_v[DW-1];
            flags_new[FB_Z] = (diff_v == '0);
            flags_new[FB_H] = hbor;
            flags_new[FB_N] = 1'b1;
            flags_new[FB_Y] = adj_v[SRC_Y_BIT];
            flags_new[FB_X] = adj_v[SRC_X_BIT];
            again = rpt && cnt_nz && (diff_v != '0);
        end else begin
            flags_new[FB_H] = 1'b0;
            flags_new[FB_N] = 1'b0;
            flags_new[FB_Y] = sum_v[SRC_Y_BIT];
            flags_new[FB_X] = sum_v[SRC_X_BIT];
            again = rpt && cnt_nz;
        end
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blk_xfer_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    is_cmp,
    input  logic    mem_ack,
    output seq_st_e st,
    output logic    busy,
    output logic    accept,
    output logic    byte_take,
    output logic    commit,
    output logic    mem_req,
    output logic    mem_we
);
    typedef struct packed {
        seq_st_e st;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        accept    = 1'b0;
        byte_take = 1'b0;
        commit    = 1'b0;
        unique case (r_q.st)
            SQ_IDLE: begin
                if (start) begin
                    accept  = 1'b1;
                    r_d.st  = SQ_READ;
                end
            end
            SQ_READ: begin
                if (mem_ack) begin
                    byte_take = 1'b1;
                    if (is_cmp) begin
                        commit = 1'b1;
                        r_d.st = SQ_IDLE;
                    end else begin
                        r_d.st = SQ_WRITE;
                    end
                end
            end
            SQ_WRITE: begin
                if (mem_ack) begin
                    commit = 1'b1;
                    r_d.st = SQ_IDLE;
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '{st: SQ_IDLE};
        else
            r_q <= r_d;
    end

    assign st      = r_q.st;
    assign busy    = (r_q.st != SQ_IDLE);
    assign mem_req = (r_q.st == SQ_READ) || (r_q.st == SQ_WRITE);
    assign mem_we  = (r_q.st == SQ_WRITE);

    // R1: an unacknowledged request keeps its direction
    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)));

    // R9: no write phase is ever entered for a compare
    p_cmp_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !is_cmp);

    // R1: a write is only entered straight after an acknowledged read
    p_write_after_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_ack));
endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine
    import blk_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_cmp,
    input  logic          op_dec,
    input  logic          op_rpt,
    input  logic [AW-1:0] hl_in,
    input  logic [AW-1:0] de_in,
    input  logic [AW-1:0] bc_in,
    input  logic [DW-1:0] acc_in,
    input  logic [7:0]    flags_in,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          rewind,
    output logic [AW-1:0] hl_out,
    output logic [AW-1:0] de_out,
    output logic [AW-1:0] bc_out,
    output logic [7:0]    flags_out
);
    typedef struct packed {
        op_mode_t      op;
        logic [AW-1:0] hl;
        logic [AW-1:0] de;
        logic [AW-1:0] bc;
        logic [DW-1:0] acc;
        logic [7:0]    flg;
        logic [DW-1:0] byt;
        logic [AW-1:0] hl_o;
        logic [AW-1:0] de_o;
        logic [AW-1:0] bc_o;
        logic [7:0]    flg_o;
        logic          done;
        logic          rewind;
    } eng_regs_t;

    eng_regs_t s_q, s_d;

    seq_st_e       st;
    logic          accept, byte_take, commit;
    logic [AW-1:0] hl_nx, de_nx, bc_nx;
    logic [DW-1:0] flag_data;
    logic [7:0]    flags_nx;
    logic          again;

    blk_xfer_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_cmp    (s_q.op.cmp),
        .mem_ack   (mem_ack),
        .st        (st),
        .busy      (busy),
        .accept    (accept),
        .byte_take (byte_take),
        .commit    (commit),
        .mem_req   (mem_req),
        .mem_we    (mem_we)
    );

    blk_xfer_step #(.W(AW)) u_step_src (
        .val (s_q.hl), .en (1'b1), .down (s_q.op.dec), .nxt (hl_nx)
    );

    blk_xfer_step #(.W(AW)) u_step_dst (
        .val (s_q.de), .en (!s_q.op.cmp), .down (s_q.op.dec), .nxt (de_nx)
    );

    blk_xfer_step #(.W(AW)) u_step_cnt (
        .val (s_q.bc), .en (1'b1), .down (1'b1), .nxt (bc_nx)
    );

    assign flag_data = (st == SQ_READ) ? mem_rdata : s_q.byt;

    blk_xfer_flags #(.DW(DW), .CW(AW)) u_flags (
        .is_cmp    (s_q.op.cmp),
        .rpt       (s_q.op.rpt),
        .data      (flag_data),
        .acc       (s_q.acc),
        .flags_old (s_q.flg),
        .cnt_next  (bc_nx),
        .flags_new (flags_nx),
        .again     (again)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.rewind = 1'b0;
        if (accept) begin
            s_d.op  = '{cmp: op_cmp, dec: op_dec, rpt: op_rpt};
            s_d.hl  = hl_in;
            s_d.de  = de_in;
            s_d.bc  = bc_in;
            s_d.acc = acc_in;
            s_d.flg = flags_in;
        end
        if (byte_take)
            s_d.byt = mem_rdata;
        if (commit) begin
            s_d.hl_o   = hl_nx;
            s_d.de_o   = de_nx;
            s_d.bc_o   = bc_nx;
            s_d.flg_o  = flags_nx;
            s_d.done   = 1'b1;
            s_d.rewind = again;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign mem_addr  = (st == SQ_WRITE) ? s_q.de : s_q.hl;
    assign mem_wdata = s_q.byt;
    assign done      = s_q.done;
    assign rewind    = s_q.rewind;
    assign hl_out    = s_q.hl_o;
    assign de_out    = s_q.de_o;
    assign bc_out    = s_q.bc_o;
    assign flags_out = s_q.flg_o;

    // R1: address held while a request waits
    p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    // R10: done lasts one cycle and coincides with idle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: rewind only accompanies a completion
    p_rewind_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |-> done);

    // R5: carry passes through untouched
    p_carry_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_out[FB_C] == s_q.flg[FB_C]));

    // R4: parity/overflow bit tracks the remaining count
    p_pv_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_out[FB_P] == (bc_out != '0)));
endmodule

// File: tb/blk_xfer_engine_tb.sv
`timescale 1ns/1ps
module blk_xfer_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_cmp = 1'b0, op_dec = 1'b0, op_rpt = 1'b0;
    logic [15:0] hl_in = '0, de_in = '0, bc_in = '0;
    logic [7:0]  acc_in = '0, flags_in = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, done, rewind;
    logic [15:0] hl_out, de_out, bc_out;
    logic [7:0]  flags_out;

    always #4 clk = ~clk;

    blk_xfer_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_cmp(op_cmp), .op_dec(op_dec), .op_rpt(op_rpt),
        .hl_in(hl_in), .de_in(de_in), .bc_in(bc_in),
        .acc_in(acc_in), .flags_in(flags_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .rewind(rewind),
        .hl_out(hl_out), .de_out(de_out), .bc_out(bc_out),
        .flags_out(flags_out)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural memory: 256 bytes indexed by the low address byte
    logic [7:0] mem [256];
    int  lat = 0;
    int  wait_cnt = 0;
    int  rd_cnt = 0, wr_cnt = 0, order_err = 0, cmp_mode = 0;
    logic [15:0] last_waddr, last_raddr;
    logic [7:0]  last_wdata;

    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + 3) & 255);
    end

    always @(negedge clk) begin
        mem_ack <= 1'b0;
        if (rst_n && mem_req) begin
            if (wait_cnt >= lat) begin
                wait_cnt = 0;
                mem_ack   <= 1'b1;
                if (mem_we) begin
                    if (rd_cnt == 0) order_err++;
                    if (cmp_mode != 0) order_err++;
                    wr_cnt++;
                    last_waddr = mem_addr;
                    last_wdata = mem_wdata;
                    mem[mem_addr[7:0]] = mem_wdata;
                end else begin
                    rd_cnt++;
                    last_raddr = mem_addr;
                    mem_rdata <= mem[mem_addr[7:0]];
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [15:0] r_hl, r_de, r_bc;
    logic [7:0]  r_f;
    logic        r_rw;

    task automatic run_op(input bit cmp, input bit dec, input bit rpt,
                          input logic [15:0] hl, input logic [15:0] de,
                          input logic [15:0] bc, input logic [7:0] a,
                          input logic [7:0] f, input bit poke);
        logic [7:0]  b, s, d, t;
        logic [15:0] e_hl, e_de, e_bc;
        logic [7:0]  e_f;
        bit          h, e_rw;
        int          guard;
        b    = mem[hl[7:0]];
        e_hl = dec ? hl - 16'd1 : hl + 16'd1;
        e_de = cmp ? de : (dec ? de - 16'd1 : de + 16'd1);
        e_bc = bc - 16'd1;
        e_f  = f;
        e_f[2] = (e_bc != 0);
        if (!cmp) begin
            s = b + a;
            e_f[4] = 1'b0; e_f[1] = 1'b0;
            e_f[5] = s[1]; e_f[3] = s[3];
            e_rw = rpt && (e_bc != 0);
        end else begin
            d = a - b;
            h = (a[3:0] < b[3:0]);
            t = d - {7'd0, h};
            e_f[7] = d[7]; e_f[6] = (d == 0); e_f[4] = h; e_f[1] = 1'b1;
            e_f[5] = t[1]; e_f[3] = t[3];
            e_rw = rpt && (e_bc != 0) && (d != 0);
        end
        rd_cnt = 0; wr_cnt = 0; order_err = 0; cmp_mode = cmp;
        @(negedge clk);
        op_cmp = cmp; op_dec = dec; op_rpt = rpt;
        hl_in = hl; de_in = de; bc_in = bc; acc_in = a; flags_in = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 200) begin
            if (poke && guard == 1) begin
                op_cmp = ~cmp; hl_in = 16'h0042; bc_in = 16'h0009; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        chk(done === 1'b1, "R10", "done seen", {31'd0, done}, 1);
        chk(hl_out === e_hl, "R2", "hl_out", hl_out, e_hl);
        chk(de_out === e_de, "R2", "de_out", de_out, e_de);
        chk(bc_out === e_bc, "R3", "bc_out", bc_out, e_bc);
        chk(flags_out === e_f, cmp ? "R5/R6" : "R4", "flags_out", flags_out, e_f);
        chk(rewind === e_rw, cmp ? "R8" : "R7", "rewind", {31'd0, rewind}, {31'd0, e_rw});
        chk(busy === 1'b0, "R10", "busy at done", {31'd0, busy}, 0);
        chk(rd_cnt == 1 && last_raddr == hl, "R1", "read count/addr", last_raddr, hl);
        if (cmp)
            chk(wr_cnt == 0, "R9", "compare writes", wr_cnt, 0);
        else
            chk(wr_cnt == 1 && last_waddr == de && last_wdata == b && order_err == 0,
                "R1", "write addr/data", {last_waddr, last_wdata}, {de, b});
        r_hl = hl_out; r_de = de_out; r_bc = bc_out; r_f = flags_out; r_rw = rewind;
        @(negedge clk);
        chk(done === 1'b0 && mem_req === 1'b0, "R10", "single pulse, no restart",
            {30'd0, done, mem_req}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int iters;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(mem_req === 1'b0 && busy === 1'b0 && done === 1'b0 && rewind === 1'b0,
            "R11", "control at reset", {28'd0, mem_req, busy, done, rewind}, 0);
        chk(hl_out === 0 && de_out === 0 && bc_out === 0 && flags_out === 0,
            "R11", "results at reset", {hl_out, bc_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R4: ascending single move
        lat = 0;
        run_op(0, 0, 0, 16'h1010, 16'h1080, 16'd5, 8'h21, 8'hC1, 0);
        // R3/R4: descending single move to zero count
        lat = 1;
        run_op(0, 1, 0, 16'h2020, 16'h20A0, 16'd1, 8'h0E, 8'h12, 0);
        // R2/R3/R7: wrap both ways, zero count, repeating
        run_op(0, 0, 1, 16'hFFFF, 16'h0000, 16'h0000, 8'h7F, 8'h00, 0);
        run_op(0, 1, 1, 16'h0000, 16'hFFFF, 16'h0003, 8'h55, 8'hFF, 0);

        // R5/R6: compare match and nibble borrow
        lat = 0;
        mem[8'h30] = 8'h5A;
        run_op(1, 0, 0, 16'h0030, 16'h1234, 16'd4, 8'h5A, 8'h01, 0);
        mem[8'h31] = 8'h0F;
        run_op(1, 1, 0, 16'h0031, 16'h4321, 16'd1, 8'h10, 8'h00, 0);
        mem[8'h32] = 8'hC3;
        run_op(1, 0, 1, 16'h0032, 16'h0000, 16'd0, 8'h02, 8'h01, 0);

        // R8: repeating search that stops on a match at offset 3
        for (int i = 0; i < 8; i++) mem[8'h40 + i] = 8'h90 + 8'(i);
        mem[8'h43] = 8'hEE;
        iters = 0;
        run_op(1, 0, 1, 16'h0040, 16'h0000, 16'd10, 8'hEE, 8'h00, 0);
        iters++;
        while (r_rw && iters < 20) begin
            run_op(1, 0, 1, r_hl, r_de, r_bc, 8'hEE, r_f, 0);
            iters++;
        end
        chk(iters == 4, "R8", "match iterations", iters, 4);
        chk(r_f[6] == 1'b1 && r_bc == 16'd6, "R8", "match Z/count", {r_f, r_bc}, {8'h00, 16'd6});

        // R8: repeating search that exhausts its count
        iters = 0;
        run_op(1, 1, 1, 16'h0047, 16'h0000, 16'd2, 8'h01, 8'h00, 0);
        iters++;
        while (r_rw && iters < 20) begin
            run_op(1, 1, 1, r_hl, r_de, r_bc, 8'h01, r_f, 0);
            iters++;
        end
        chk(iters == 2 && r_f[2] == 1'b0 && r_f[6] == 1'b0, "R8", "exhaust stop",
            iters, 2);

        // R7: repeating descending copy of three bytes
        for (int i = 0; i < 3; i++) mem[8'h60 + i] = 8'hA0 + 8'(i);
        iters = 0;
        lat = 1;
        run_op(0, 1, 1, 16'h0062, 16'h0072, 16'd3, 8'h00, 8'h00, 0);
        iters++;
        while (r_rw && iters < 20) begin
            run_op(0, 1, 1, r_hl, r_de, r_bc, 8'h00, r_f, 0);
            iters++;
        end
        chk(iters == 3, "R7", "copy iterations", iters, 3);
        for (int i = 0; i < 3; i++)
            chk(mem[8'h70 + i] == 8'hA0 + 8'(i), "R7", "copied byte",
                mem[8'h70 + i], 8'hA0 + 8'(i));

        // R10: start pulse during a slow move is ignored
        lat = 2;
        run_op(0, 0, 0, 16'h0050, 16'h00D0, 16'd7, 8'h33, 8'h80, 1);
        lat = 0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule